// File: doc/BRIEF.md
# Shifted-Operand Integer ALU with Flag Store

This is the execute stage of a 64-bit integer datapath. Each operation takes two sources. The second source can first pass through a barrel shifter, or a 12-bit immediate can replace it. The unit offers these operations:

- add, subtract, add with carry and subtract with borrow;
- six bitwise operations, three of which invert the second operand;
- three forms of 16-bit halfword move;
- unsigned field extract, signed field extract and field insert.

The result is combinational and comes out in the same cycle as the inputs.

Next-state flags are N (negative), Z (zero), C (carry) and V (overflow). The unit computes them next to the result, and a small register holds them. Only the flag-setting forms of arithmetic, AND and AND-NOT change the held value. Every other operation passes the held flags through unchanged. The carry consumed by the carry-using arithmetic comes in on its own pin. The surrounding pipeline can therefore feed it from the store or from a bypass.

Top module: `shift_op_alu`

## Requirements
- R1: While `rst_n` is low, `flags_q` is 0. The flag vector order is {N,Z,C,V} in bits [3:0].
- R2: With `imm_sel`=0, the second operand is `src_b` shifted by `shift_kind` (0 logical left, 1 logical right, 2 arithmetic right with sign fill, 3 rotate right). The shift distance is `shift_amt[5:0]`, and bits [7:6] of `shift_amt` have no effect.
- R3: With `imm_sel`=1, the second operand is the zero-extended `imm12`, shifted left by 12 when `imm_lsl12`=1. The shifter is bypassed in this case.
- R4: The `op` codes 0 to 3 give a+b, a-b, a+b+c_in and a-b-(1-c_in), each modulo 2^64.
- R5: The `op` codes 4 to 9 give a&b, a|b, a^b, a&~b, a|~b and a^~b.
- R6: For a flag-setting `op` from 0 to 3, the flags are set as follows:
  - N is the result MSB, and Z is set when the result is zero.
  - C is the unsigned carry out. For codes 1 and 3 this is the same as "no borrow".
  - V is set when the result overflows as a signed 64-bit value.
- R7: For a flag-setting AND (4) or AND-NOT (7), N and Z come from the result, and C and V are 0.
- R8: Flags change only when `set_flags`=1 and `op` is 0, 1, 2, 3, 4 or 7. In every other case `flags_nxt` equals `flags_q`.
- R9: At each rising clock edge after reset, `flags_q` takes the value of `flags_nxt`.
- R10: The halfword moves are `op` 10 (zero other bits), 11 (keep the other bits of `src_a`) and 12 (bitwise inverse of the placed value). Each places `mov_imm` at bit 16*`mov_hw`.
- R11: `op` 13 returns `src_b` shifted right by `fld_lsb`, masked to `fld_wm1`+1 bits. `op` 14 does the same and then sign-extends from the top bit of the field. Only fields with `fld_lsb`+`fld_wm1` below 64 are defined.
- R12: `op` 15 returns `src_a` with bits [`fld_lsb` +: `fld_wm1`+1] replaced by the low bits of `src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag store |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Flag-setting form select |
| c_in | input | 1 | Carry consumed by codes 2 and 3 |
| src_a | input | 64 | First source and destination for keep/insert |
| src_b | input | 64 | Second source |
| imm_sel | input | 1 | Use immediate as second operand |
| imm12 | input | 12 | Arithmetic/logical immediate |
| imm_lsl12 | input | 1 | Shift immediate left by 12 |
| shift_kind | input | 2 | Second-operand shift type |
| shift_amt | input | 8 | Shift distance, low 6 bits used |
| mov_imm | input | 16 | Halfword move value |
| mov_hw | input | 2 | Halfword position |
| fld_lsb | input | 6 | Field start bit |
| fld_wm1 | input | 6 | Field width minus one |
| result | output | 64 | Operation result |
| flags_nxt | output | 4 | Next flags {N,Z,C,V} |
| flags_q | output | 4 | Held flags {N,Z,C,V} |

## Verification
The only internal state is the flag register. If it is corrupted, `flags_q` shows the wrong value one edge after the faulty update. It also shows directly on `flags_nxt` in every following cycle that runs a non-flag operation, because those cycles pass it through. A wrong shift or mask is combinational and shows on `result` in the same cycle as the stimulus. The bench sweeps every shift distance, every legal field position and width, and boundary operands (zero, all ones, the most negative value and the most positive value), so that carry and overflow corners appear in the cycle they are applied.

// File: rtl/shift_op_alu.sv
module shift_op_alu #(
  parameter int W     = 64,
  parameter int AMT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               op,
  input  logic                     set_flags,
  input  logic                     c_in,
  input  logic [W-1:0]             src_a,
  input  logic [W-1:0]             src_b,
  input  logic                     imm_sel,
  input  logic [11:0]              imm12,
  input  logic                     imm_lsl12,
  input  logic [1:0]               shift_kind,
  input  logic [AMT_W-1:0]         shift_amt,
  input  logic [15:0]              mov_imm,
  input  logic [$clog2(W/16)-1:0]  mov_hw,
  input  logic [$clog2(W)-1:0]     fld_lsb,
  input  logic [$clog2(W)-1:0]     fld_wm1,
  output logic [W-1:0]             result,
  output logic [3:0]               flags_nxt,
  output logic [3:0]               flags_q
);
  localparam int SW = $clog2(W);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_ADC = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_ORR = 4'd5,  OP_EOR = 4'd6,  OP_BIC = 4'd7;
  localparam logic [3:0] OP_ORN = 4'd8,  OP_EON = 4'd9,  OP_MVZ = 4'd10, OP_MVK = 4'd11;
  localparam logic [3:0] OP_MVN = 4'd12, OP_UFX = 4'd13, OP_SFX = 4'd14, OP_FIN = 4'd15;

  logic [SW-1:0] amt;
  logic [W-1:0]  b_sh, b_imm, opb;
  assign amt = shift_amt[SW-1:0];

  always_comb begin
    case (shift_kind)
      2'd0:    b_sh = src_b << amt;
      2'd1:    b_sh = src_b >> amt;
      2'd2:    b_sh = $unsigned($signed(src_b) >>> amt);
      default: b_sh = (src_b >> amt) | (src_b << (W - int'(amt)));
    endcase
  end

  assign b_imm = imm_lsl12 ? ({{(W-12){1'b0}}, imm12} << 12) : {{(W-12){1'b0}}, imm12};
  assign opb   = imm_sel ? b_imm : b_sh;

  logic         is_sub, cin_eff, c_out, v_out;
  logic [W-1:0] b_add, sum;
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC);
  assign b_add   = is_sub ? ~opb : opb;
  assign cin_eff = (op == OP_ADD) ? 1'b0 : (op == OP_SUB) ? 1'b1 : c_in;
  assign {c_out, sum} = {1'b0, src_a} + {1'b0, b_add} + {{W{1'b0}}, cin_eff};
  assign v_out   = (src_a[W-1] == b_add[W-1]) && (sum[W-1] != src_a[W-1]);

  logic [SW-1:0] hsh;
  logic [W-1:0]  placed, hmask;
  assign hsh    = SW'({mov_hw, 4'b0000});
  assign placed = {{(W-16){1'b0}}, mov_imm} << hsh;
  assign hmask  = {{(W-16){1'b0}}, 16'hFFFF} << hsh;

  logic [SW:0]   wid;
  logic [W-1:0]  fmask, ext;
  assign wid   = {1'b0, fld_wm1} + 1'b1;
  assign fmask = ~({W{1'b1}} << wid);
  assign ext   = (src_b >> fld_lsb) & fmask;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADC, OP_SBC: result = sum;
      OP_AND: result = src_a & opb;
      OP_ORR: result = src_a | opb;
      OP_EOR: result = src_a ^ opb;
      OP_BIC: result = src_a & ~opb;
      OP_ORN: result = src_a | ~opb;
      OP_EON: result = src_a ^ ~opb;
      OP_MVZ: result = placed;
      OP_MVK: result = (src_a & ~hmask) | placed;
      OP_MVN: result = ~placed;
      OP_UFX: result = ext;
      OP_SFX: result = ext | (ext[fld_wm1] ? ~fmask : {W{1'b0}});
      default: result = (src_a & ~(fmask << fld_lsb)) | ((src_b & fmask) << fld_lsb);
    endcase
  end

  logic       arith, flag_op;
  logic [3:0] fcalc;
  assign arith   = (op <= OP_SBC);
  assign flag_op = set_flags && (arith || op == OP_AND || op == OP_BIC);
  assign fcalc   = arith ? {sum[W-1], sum == '0, c_out, v_out}
                         : {result[W-1], result == '0, 2'b00};
  assign flags_nxt = flag_op ? fcalc : flags_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= 4'b0000;
    else        flags_q <= flags_nxt;
endmodule

module shift_op_alu_chk #(parameter int W = 64) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [3:0]              op,
  input logic                    set_flags,
  input logic [W-1:0]            result,
  input logic [3:0]              flags_nxt,
  input logic [3:0]              flags_q,
  input logic [$clog2(W/16)-1:0] mov_hw,
  input logic [$clog2(W)-1:0]    fld_wm1
);
  logic [W-1:0] hw_keep;
  assign hw_keep = {{(W-16){1'b0}}, 16'hFFFF} << (16 * int'(mov_hw));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |-> flags_nxt == flags_q);
  assert_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> flags_q == $past(flags_q));
  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op <= 4'd3) |-> flags_nxt[2] == (result == '0));
  assert_logic_cv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && (op == 4'd4 || op == 4'd7)) |-> flags_nxt[1:0] == 2'b00);
  assert_movz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd10 |-> (result & ~hw_keep) == '0);
  assert_ufx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd13 |-> (result >> (int'(fld_wm1) + 1)) == '0);
endmodule

bind shift_op_alu shift_op_alu_chk #(.W(W)) u_chk (.*);

// File: tb/shift_op_alu_tb.sv
module shift_op_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic        set_flags = 1'b0, c_in = 1'b0, imm_sel = 1'b0, imm_lsl12 = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [11:0] imm12 = '0;
  logic [1:0]  shift_kind = '0;
  logic [7:0]  shift_amt = '0;
  logic [15:0] mov_imm = '0;
  logic [1:0]  mov_hw = '0;
  logic [5:0]  fld_lsb = '0, fld_wm1 = '0;
  logic [63:0] result;
  logic [3:0]  flags_nxt, flags_q;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [3:0] exp_q = 4'b0000;

  always #2 clk = ~clk;

  shift_op_alu u_dut (.*);

  logic [63:0] pats [6];
  initial begin
    pats[0] = 64'h0; pats[1] = '1; pats[2] = 64'h8000_0000_0000_0000;
    pats[3] = 64'h7FFF_FFFF_FFFF_FFFF; pats[4] = 64'h1; pats[5] = 64'h0123_4567_89AB_CDEF;
  end

  function automatic logic [63:0] ref_shift(logic [63:0] b, logic [1:0] k, int n);
    logic [63:0] o;
    for (int i = 0; i < 64; i++)
      case (k)
        2'd0: o[i] = (i >= n) ? b[i-n] : 1'b0;
        2'd1: o[i] = (i + n < 64) ? b[i+n] : 1'b0;
        2'd2: o[i] = (i + n < 64) ? b[i+n] : b[63];
        default: o[i] = b[(i+n)%64];
      endcase
    return o;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(string tag);
    logic [63:0] b, r;
    logic [65:0] ua, ub, ur;
    logic [3:0]  f;
    logic        fl;
    int          w;
    w = int'(fld_wm1) + 1;
    if (imm_sel) b = imm_lsl12 ? 64'(imm12) * 64'd4096 : 64'(imm12);
    else b = ref_shift(src_b, shift_kind, int'(shift_amt % 8'd64));
    ua = {{2{src_a[63]}}, src_a}; ub = {{2{b[63]}}, b};
    ur = '0; r = '0;
    case (op)
      4'd0: ur = ua + ub;
      4'd1: ur = ua - ub;
      4'd2: ur = ua + ub + 66'(c_in);
      4'd3: ur = ua - ub - 66'(!c_in);
      4'd4: r = src_a & b;
      4'd5: r = src_a | b;
      4'd6: r = src_a ^ b;
      4'd7: r = src_a & ~b;
      4'd8: r = src_a | ~b;
      4'd9: r = src_a ^ ~b;
      4'd10, 4'd11, 4'd12: begin
        r = (op == 4'd11) ? src_a : 64'h0;
        for (int i = 0; i < 16; i++) r[16*int'(mov_hw)+i] = mov_imm[i];
        if (op == 4'd12) r = ~r;
      end
      4'd13, 4'd14: begin
        for (int i = 0; i < 64; i++)
          r[i] = (i < w) ? src_b[int'(fld_lsb)+i] : (op == 4'd14 ? src_b[int'(fld_lsb)+w-1] : 1'b0);
      end
      default: begin
        r = src_a;
        for (int i = 0; i < w; i++) r[int'(fld_lsb)+i] = src_b[i];
      end
    endcase
    if (op <= 4'd3) begin
      logic [64:0] uu;
      r = ur[63:0];
      case (op)
        4'd0: uu = {1'b0, src_a} + {1'b0, b};
        4'd1: uu = {1'b0, src_a} + {1'b0, ~b} + 65'd1;
        4'd2: uu = {1'b0, src_a} + {1'b0, b} + 65'(c_in);
        default: uu = {1'b0, src_a} + {1'b0, ~b} + 65'(c_in);
      endcase
      f = {r[63], r == 64'h0, uu[64], !(ur[65] == ur[64] && ur[64] == ur[63])};
    end else f = {r[63], r == 64'h0, 2'b00};
    fl = set_flags && (op <= 4'd4 || op == 4'd7);
    if (!fl) f = exp_q;
    #1;
    vectors++;
    check(tag, "result", result, r);
    check(fl ? tag : "R8", "flags_nxt", 64'(flags_nxt), 64'(f));
    @(posedge clk);
    exp_q = f;
    #1;
    check("R9", "flags_q", 64'(flags_q), 64'(exp_q));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    check("R1", "flags_q in reset", 64'(flags_q), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: every shift kind and distance, upper amount bits toggled
    op = 4'd0;
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 64; n++)
        for (int p = 1; p < 6; p += 2) begin
          src_a = pats[(p+1)%6]; src_b = pats[p]; shift_kind = 2'(k);
          shift_amt = 8'(n) | (p == 3 ? 8'hC0 : 8'h00);
          apply("R2");
        end
    src_b = 64'h0123_4567_89AB_CDEF; shift_kind = 2'd3; shift_amt = 8'd4; op = 4'd5;
    apply("R2");
    shift_amt = 8'd0; shift_kind = 2'd0;

    // R3: immediate operand
    imm_sel = 1'b1;
    for (int v = 0; v < 4096; v += 97)
      for (int h = 0; h < 2; h++)
        for (int o = 0; o < 2; o++) begin
          op = o ? 4'd1 : 4'd0; imm12 = 12'(v); imm_lsl12 = h[0]; src_a = pats[v%6];
          set_flags = 1'b1; apply("R3");
        end
    imm12 = 12'hFFF; imm_lsl12 = 1'b1; op = 4'd0; src_a = 64'h0; apply("R3");
    imm_sel = 1'b0; imm_lsl12 = 1'b0; set_flags = 1'b0;

    // R4..R8: arithmetic and logic ops over operand corners
    for (int o = 0; o < 10; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int s = 0; s < 2; s++)
            for (int c = 0; c < 2; c++) begin
              op = 4'(o); src_a = pats[i]; src_b = pats[j];
              set_flags = s[0]; c_in = c[0];
              apply(o < 4 ? (s ? "R6" : "R4") : (s ? "R7" : "R5"));
            end
    // R8: non-flag ops with set_flags high keep the held flags
    op = 4'd1; set_flags = 1'b1; src_a = 64'h0; src_b = 64'h1; apply("R6");
    for (int o = 5; o < 16; o++) begin
      if (o == 7) continue;
      op = 4'(o); src_a = 64'h0; src_b = 64'h0; fld_lsb = '0; fld_wm1 = 6'd3;
      apply("R8");
    end
    set_flags = 1'b0;

    // R10: halfword moves
    for (int o = 10; o < 13; o++)
      for (int h = 0; h < 4; h++)
        for (int p = 0; p < 3; p++) begin
          op = 4'(o); mov_hw = 2'(h); mov_imm = 16'hBA5E ^ 16'(p * 16'h1111);
          src_a = pats[p+3]; apply("R10");
        end

    // R11, R12: every legal field position and width
    for (int o = 13; o < 16; o++)
      for (int l = 0; l < 64; l++)
        for (int wm = 0; wm + l < 64; wm++) begin
          op = 4'(o); fld_lsb = 6'(l); fld_wm1 = 6'(wm);
          src_a = 64'hF0F0_1234_5678_0F0F; src_b = 64'h9ABC_DEF0_8765_4321 ^ 64'(l);
          apply(o == 15 ? "R12" : "R11");
        end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule